// File: doc/BRIEF.md
# Four-Mode Clock Divider

This block derives a clock-like output from a reference clock. Two select inputs choose at run time between a stopped output, a quarter-rate output, a half-rate output and the reference clock passed straight through. Both divided rates come from one shared free-running counter. Each counter bit goes through its own register stage, so the divided waveforms change only just after reference rising edges.

The select inputs feed a multiplexer directly, so a new mode shows on the output without waiting for a clock edge. The counter never pauses, not even while the output is stopped. A later change to a divided mode therefore picks up the running phase with no restart sequence. Reset is synchronous and active-low. While it is held, the output stays low in every mode.

Top module: `cdiv_mode_clk`

## Requirements
- R1: With {sel_hi, sel_lo} = 00 (stop), clk_out is 0 at every instant.
- R2: With {sel_hi, sel_lo} = 01 (slow), clk_out runs at one quarter of the reference rate with 50% duty. Just after the k-th rising edge since reset release (k >= 1), it equals bit 1 of (k-1).
- R3: With {sel_hi, sel_lo} = 10 (medium), clk_out runs at half the reference rate with 50% duty. Just after the k-th rising edge since reset release, it equals bit 0 of (k-1).
- R4: With {sel_hi, sel_lo} = 11 (fast), clk_out follows clk_ref in both clock phases.
- R5: While rst_n is low, clk_out is 0 in every mode, including fast. A rising edge with rst_n low clears the counter and the divided-bit registers.
- R6: The divide counter advances on every rising edge whatever the mode, stop included. After a stop interval, a divided mode resumes with the phase given by the total number of edges since reset release.
- R7: A change of the select inputs reaches clk_out without waiting for a clock edge.
- R8: After reset release, the medium output first goes high just after the 2nd rising edge, and the slow output just after the 3rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_hi | input | 1 | Mode select, upper bit |
| sel_lo | input | 1 | Mode select, lower bit |
| clk_out | output | 1 | Derived clock output |

## Verification
Directed sequences hold each mode for several reference periods after reset. These separate the half-rate and quarter-rate waveforms by their phase against an edge count kept in the bench, and show the pass-through output high and low within one period. A stop interval followed by a divided mode tells a counter that keeps running apart from one that pauses. Checks taken straight after a select change, within the same low phase, confirm that the switch does not wait for an edge. Random mode switches mixed with occasional resets, asserted in fast mode as well, test every pairing of old and new mode and confirm that reset forces the output low even when the reference clock is high.

// File: rtl/clkdiv_pkg.sv
// Package: shared mode type for the four-mode clock divider.
// Assumes the select pair is packed as {sel_hi, sel_lo}.
package clkdiv_pkg;
    typedef enum logic [1:0] {
        MODE_STOP   = 2'b00,
        MODE_SLOW   = 2'b01,
        MODE_MEDIUM = 2'b10,
        MODE_FAST   = 2'b11
    } mode_t;
endpackage

// File: rtl/cdiv_counter.sv
// Module: free-running binary counter that feeds the divided rates.
// Assumes a synchronous active-low reset; wraps modulo 2**CNT_W.
module cdiv_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Advance on every edge, regardless of the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + ONE;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt == $past(cnt) + ONE)); // R6
endmodule

// File: rtl/cdiv_tap_stage.sv
// Module: one register stage per counter bit, producing glitch-free taps.
// Assumes the input bits change only at clk rising edges.
module cdiv_tap_stage #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] tap
);
    localparam int MSB = CNT_W - 1;

    genvar gi;
    generate
        for (gi = 0; gi < CNT_W; gi++) begin : g_tap
            // Retime counter bit gi into its tap register.
            always_ff @(posedge clk) begin
                if (!rst_n) tap[gi] <= 1'b0;
                else        tap[gi] <= cnt_in[gi];
            end
        end
    endgenerate

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (tap[0] != $past(tap[0]))); // R3

    AST_TOP_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (tap[MSB] != $past(tap[MSB]))) |-> $past(&tap[MSB-1:0])); // R2
endmodule

// File: rtl/cdiv_out_mux.sv
// Module: combinational mode selector for the output clock.
// Assumes the taps come from registers; fast mode passes the reference clock.
module cdiv_out_mux #(
    parameter int CNT_W = 2
) (
    input  logic                 clk_ref,
    input  logic                 rst_n,
    input  clkdiv_pkg::mode_t    mode,
    input  logic [CNT_W-1:0]     tap,
    output logic                 clk_out
);
    import clkdiv_pkg::*;
    localparam int SLOW_BIT = CNT_W - 1;

    logic pick;

    // Choose the source for the current mode.
    always_comb begin
        unique case (mode)
            MODE_STOP:   pick = 1'b0;
            MODE_SLOW:   pick = tap[SLOW_BIT];
            MODE_MEDIUM: pick = tap[0];
            MODE_FAST:   pick = clk_ref;
            default:     pick = 1'b0;
        endcase
    end

    // Hold the output low while reset is asserted.
    always_comb begin
        clk_out = rst_n & pick;
    end
endmodule

// File: rtl/cdiv_mode_clk.sv
// Module: top of the four-mode clock divider.
// Assumes sel_hi/sel_lo may change at any time; the output follows at once.
module cdiv_mode_clk #(
    parameter int CNT_W = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic sel_hi,
    input  logic sel_lo,
    output logic clk_out
);
    import clkdiv_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tap;
    mode_t            mode;

    // Pack the select inputs into the mode type.
    always_comb begin
        mode = mode_t'({sel_hi, sel_lo});
    end

    cdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .cnt    (cnt)
    );

    cdiv_tap_stage #(.CNT_W(CNT_W)) u_tap (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .cnt_in (cnt),
        .tap    (tap)
    );

    cdiv_out_mux #(.CNT_W(CNT_W)) u_mux (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .mode    (mode),
        .tap     (tap),
        .clk_out (clk_out)
    );

    AST_STOP_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode == MODE_STOP) |-> !clk_out); // R1
endmodule

// File: tb/sim_cdiv_mode_clk.sv
module sim_cdiv_mode_clk;
    localparam int PER = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic clk_out;

    int n_chk = 0;
    int n_fail = 0;
    int k = 0;
    bit done = 1'b0;

    always #(PER/2) clk = ~clk;

    cdiv_mode_clk u0 (
        .clk_ref (clk),
        .rst_n   (rst_n),
        .sel_hi  (sel[1]),
        .sel_lo  (sel[0]),
        .clk_out (clk_out)
    );

    // Expected output from mode, edge count since release and clock level.
    function automatic logic exp_out(input logic [1:0] s, input int kk,
                                     input logic ck, input logic r);
        int m;
        if (!r) return 1'b0;
        m = (kk > 0) ? kk - 1 : 0;
        case (s)
            2'b00: return 1'b0;
            2'b01: return (kk > 0) ? logic'((m >> 1) & 1) : 1'b0;
            2'b10: return (kk > 0) ? logic'(m & 1) : 1'b0;
            default: return ck;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] s, input logic r);
        if (!r) return "R5";
        case (s)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string ctx);
        logic e;
        e = exp_out(sel, k, clk, rst_n);
        n_chk++;
        if (clk_out !== e) begin
            n_fail++;
            $display("FAIL %s %s: t=%0t sel=%b k=%0d clk_out=%b expected %b",
                     req_of(sel, rst_n), ctx, $time, sel, k, clk_out, e);
        end
    endtask

    // One reference period: drive after a falling edge, check in both phases.
    task automatic cyc(input logic [1:0] s, input logic r, input string ctx);
        sel = s;
        rst_n = r;
        #1 chk({ctx, " R7 immediate"});
        @(posedge clk);
        if (r) k++; else k = 0;
        #1 chk({ctx, " high phase"});
        @(negedge clk);
        #1 chk({ctx, " low phase"});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        // R5: reset state in every mode, including fast while clk is high.
        for (int m = 0; m < 4; m++) cyc(m[1:0], 1'b0, "R5 reset");
        // R8 / R2 / R3: first edges after release, medium then slow.
        for (int i = 0; i < 8; i++) cyc(2'b10, 1'b1, "R8 medium start");
        for (int i = 0; i < 2; i++) cyc(2'b11, 1'b0, "R5 reset fast");
        for (int i = 0; i < 9; i++) cyc(2'b01, 1'b1, "R8 slow start");
        // R4: pass-through.
        for (int i = 0; i < 4; i++) cyc(2'b11, 1'b1, "R4 fast");
        // R6: stop for an odd count, then divided phases must continue.
        for (int i = 0; i < 5; i++) cyc(2'b00, 1'b1, "R6 stop");
        for (int i = 0; i < 4; i++) cyc(2'b10, 1'b1, "R6 resume medium");
        for (int i = 0; i < 3; i++) cyc(2'b00, 1'b1, "R6 stop");
        for (int i = 0; i < 6; i++) cyc(2'b01, 1'b1, "R6 resume slow");
        // Random mode switches and occasional resets.
        for (int i = 0; i < 400; i++) begin
            logic [1:0] s;
            logic r;
            s = sel;
            if (($urandom % 4) == 0) s = 2'($urandom % 4);
            r = (($urandom % 40) != 0);
            cyc(s, r, "random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PER * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule